// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block models the slave side of a small serial EEPROM, 512 cells by default, that sits on an open-drain two-wire bus. SCL and SDA are oversampled with the system clock. The block finds start, repeated-start and stop conditions and checks the selection byte against a fixed device code and the strap inputs. It acknowledges bytes by pulling SDA low. A cell address counter sets which register-array cell a data byte is written to or read from.

A write transfer sends a selection with write intent, then one cell address byte, then any number of data bytes. A read transfer either continues from the current counter value, or follows an address-setting write with a repeated start. If a write transfer stored at least one byte, the stop that ends it starts an internal write cycle of fixed length. During that cycle the slave leaves SDA alone. A write-lock input causes data bytes to be refused.

Top module: `seeprom_slave`

## Requirements
- R1: After reset, sda_pull_o is low and no write cycle is pending, so the first valid selection is acknowledged.
- R2: A selection byte is acknowledged only when bits 7:4 equal 1010, bits 3:2 equal strap_i[2:1] (512-cell build) and no write cycle is running. Bit 0 set means read intent. Any other selection gets no acknowledge, and the slave ignores the bus until the next start.
- R3: In the 512-cell build, selection bit 1 is taken as cell address bit 8 and is never compared with strap_i[0].
- R4: After a write selection, the first byte is loaded as the low eight address bits. Each following byte is acknowledged, stored at the counter, and the counter then steps by one.
- R5: A read selection sends the cell at the current counter, and the counter steps after every byte sent. The counter wraps from cell 511 to cell 0.
- R6: After the master answers a read byte with NACK, the slave drives SDA no more until the next start.
- R7: A stop that ends a transfer which stored at least one data byte starts a write cycle of WRITE_CYCLES clocks. Every selection during that cycle gets no acknowledge. A stop that ends a transfer which stored no data starts no write cycle.
- R8: While wr_lock_i is high, the address byte is still acknowledged, but data bytes are not acknowledged, no cell changes and no write cycle follows.
- R9: sda_pull_o changes only while SCL is low.
- R10: A start seen in the middle of a byte discards the bits received so far. The counter and memory stay unchanged, and a new selection byte is expected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| strap_i | input | 3 | Board-strapped sub-address bits |
| wr_lock_i | input | 1 | High blocks data writes; low or tied off allows them |
| sda_pull_o | output | 1 | High pulls the data line low (open-drain enable) |

## Verification
Each line passes through two synchronizer flops and one edge-compare stage. An SCL fall therefore shows up on sda_pull_o three clocks later, and an SCL rise is sampled three clocks after the master raises it. The bench changes its own SDA two clocks after lowering SCL. It holds each SCL phase for five clocks and reads the line two clocks after raising SCL, which is well after any slave update. Write-cycle timing is checked by recording the clock count at the stop and comparing it with the count at the first acknowledged poll. A monitor flags any change of sda_pull_o while the bench holds SCL high.

// File: rtl/seeprom_pkg.sv
// Shared types and constants for the two-wire EEPROM slave.
package seeprom_pkg;
    // Fixed device code matched against the upper nibble of the selection byte.
    localparam logic [3:0] DEV_CODE = 4'b1010;

    // What the byte engine is doing on the bus.
    typedef enum logic [1:0] {
        LNK_IDLE,
        LNK_RX,
        LNK_TX
    } lnk_mode_t;

    // Meaning of the byte currently being received.
    typedef enum logic [1:0] {
        ROLE_SEL,
        ROLE_ADDR,
        ROLE_DATA
    } rx_role_t;
endpackage

// File: rtl/seeprom_bus_sense.sv
// Synchronizes SCL/SDA into the clk domain and flags clock edges plus
// start/stop conditions. Assumes both lines stay stable for several
// clk periods; resets both histories to the idle-high level.
module seeprom_bus_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    localparam int DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] scl_sh;
    logic [DEPTH-1:0] sda_sh;
    logic             scl_prev;
    logic             sda_prev;

    // Shift both lines through the synchronizer and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[DEPTH-2:0], scl_i};
            sda_sh <= {sda_sh[DEPTH-2:0], sda_i};
        end
    end

    // Compare the newest synchronized sample with the one before it.
    always_comb begin
        scl_lvl   = scl_sh[DEPTH-2];
        sda_lvl   = sda_sh[DEPTH-2];
        scl_prev  = scl_sh[DEPTH-1];
        sda_prev  = sda_sh[DEPTH-1];
        scl_rise  = scl_lvl & ~scl_prev;
        scl_fall  = ~scl_lvl & scl_prev;
        bus_start = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        bus_stop  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end
endmodule

// File: rtl/seeprom_cell_array.sv
// Byte-wide register array with one shared address, a synchronous write
// and an asynchronous read. Contents are not reset.
module seeprom_cell_array #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    // Store one byte when the controller commits a write.
    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    // Present the addressed cell to the transmit path.
    always_comb rdata = cells[addr];
endmodule

// File: rtl/seeprom_wr_timer.sv
// Counts down the internal write cycle. Assumes a kick is a single-cycle
// pulse; a kick during a running cycle restarts it.
module seeprom_wr_timer #(
    parameter int CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain;

    // Load the full length on a kick, otherwise run down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           remain <= '0;
        else if (kick)        remain <= CW'(CYCLES);
        else if (remain != 0) remain <= remain - 1'b1;
    end

    // The cycle is running while any count remains.
    always_comb busy = (remain != '0);
endmodule

// File: rtl/seeprom_link_ctrl.sv
// Bit/byte engine of the slave: receives selection, address and data
// bytes, drives acknowledges and read data, and keeps the cell counter.
// Assumes synchronized events from seeprom_bus_sense and HI_BITS in 1..3.
module seeprom_link_ctrl
    import seeprom_pkg::*;
#(
    parameter int AW      = 9,
    parameter int HI_BITS = AW - 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_lvl,
    input  logic          bus_start,
    input  logic          bus_stop,
    input  logic [2:0]    strap_i,
    input  logic          wr_lock_i,
    input  logic          busy_i,
    input  logic [7:0]    rd_byte,
    output logic          sda_pull,
    output logic          mem_we,
    output logic [7:0]    wr_byte,
    output logic [AW-1:0] cell_addr,
    output logic          wr_kick
);
    lnk_mode_t          mode;
    rx_role_t           role;
    logic [3:0]         bitcnt;
    logic [7:0]         shreg;
    logic [7:0]         tx_byte;
    logic               acked;
    logic               rd_mode;
    logic               dirty;
    logic [HI_BITS-1:0] hi_q;
    logic [AW-1:0]      addr_q;
    logic [2:0]         strap_ok;
    logic               sel_match;
    logic               rx_ack;
    logic               byte_done;

    // Strap bits that serve as address bits are exempt from the compare.
    always_comb begin
        for (int i = 0; i < 3; i++) begin
            strap_ok[i] = (i < HI_BITS) || (shreg[i+1] == strap_i[i]);
        end
        sel_match = (shreg[7:4] == DEV_CODE) && (&strap_ok) && !busy_i;
        case (role)
            ROLE_SEL:  rx_ack = sel_match;
            ROLE_ADDR: rx_ack = 1'b1;
            default:   rx_ack = !wr_lock_i;
        endcase
    end

    // Commit strobes: data write at the ack slot, write cycle at stop.
    always_comb begin
        byte_done = (mode == LNK_RX) && scl_fall && (bitcnt == 4'd8);
        mem_we    = byte_done && (role == ROLE_DATA) && !wr_lock_i;
        wr_byte   = shreg;
        cell_addr = addr_q;
        sda_pull  = tx_pull_q;
        wr_kick   = bus_stop && dirty;
    end

    logic tx_pull_q;

    // Bus state machine: conditions first, then per-mode bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= LNK_IDLE;
            role      <= ROLE_SEL;
            bitcnt    <= '0;
            shreg     <= '0;
            tx_byte   <= '0;
            acked     <= 1'b0;
            rd_mode   <= 1'b0;
            dirty     <= 1'b0;
            hi_q      <= '0;
            addr_q    <= '0;
            tx_pull_q <= 1'b0;
        end else if (bus_start) begin
            mode      <= LNK_RX;
            role      <= ROLE_SEL;
            bitcnt    <= '0;
            tx_pull_q <= 1'b0;
        end else if (bus_stop) begin
            mode      <= LNK_IDLE;
            dirty     <= 1'b0;
            tx_pull_q <= 1'b0;
        end else begin
            case (mode)
                LNK_RX: begin
                    if (scl_rise) begin
                        if (bitcnt < 4'd8) begin
                            shreg  <= {shreg[6:0], sda_lvl};
                            bitcnt <= bitcnt + 4'd1;
                        end else begin
                            bitcnt <= 4'd9;
                        end
                    end else if (byte_done) begin
                        tx_pull_q <= rx_ack;
                        acked     <= rx_ack;
                        case (role)
                            ROLE_SEL: if (rx_ack) begin
                                rd_mode <= shreg[0];
                                hi_q    <= shreg[HI_BITS:1];
                            end
                            ROLE_ADDR: addr_q <= {hi_q, shreg};
                            default: if (rx_ack) begin
                                addr_q <= addr_q + 1'b1;
                                dirty  <= 1'b1;
                            end
                        endcase
                    end else if (scl_fall && bitcnt == 4'd9) begin
                        bitcnt <= '0;
                        if (!acked) begin
                            tx_pull_q <= 1'b0;
                            mode      <= LNK_IDLE;
                        end else if (role == ROLE_SEL && rd_mode) begin
                            mode      <= LNK_TX;
                            tx_byte   <= rd_byte;
                            tx_pull_q <= ~rd_byte[7];
                        end else begin
                            tx_pull_q <= 1'b0;
                            role      <= (role == ROLE_SEL) ? ROLE_ADDR : ROLE_DATA;
                        end
                    end
                end
                LNK_TX: begin
                    if (scl_rise) begin
                        if (bitcnt < 4'd8) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else begin
                            acked  <= ~sda_lvl;
                            addr_q <= addr_q + 1'b1;
                            bitcnt <= 4'd9;
                        end
                    end else if (scl_fall) begin
                        if (bitcnt == 4'd9) begin
                            bitcnt <= '0;
                            if (acked) begin
                                tx_byte   <= rd_byte;
                                tx_pull_q <= ~rd_byte[7];
                            end else begin
                                tx_pull_q <= 1'b0;
                                mode      <= LNK_IDLE;
                            end
                        end else if (bitcnt == 4'd8) begin
                            tx_pull_q <= 1'b0;
                        end else begin
                            tx_pull_q <= ~tx_byte[3'd7 - bitcnt[2:0]];
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/seeprom_slave.sv
// Top of the two-wire EEPROM slave: bus sensing, byte engine, cell array
// and write-cycle timer. Assumes MEM_BYTES is a power of two from 512 to
// 2048 and that scl_i/sda_i carry the resolved bus levels.
module seeprom_slave #(
    parameter int MEM_BYTES    = 512,
    parameter int WRITE_CYCLES = 400,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wr_lock_i,
    output logic       sda_pull_o
);
    localparam int AW      = $clog2(MEM_BYTES);
    localparam int HI_BITS = AW - 8;

    logic          scl_lvl;
    logic          sda_lvl;
    logic          scl_rise;
    logic          scl_fall;
    logic          bus_start;
    logic          bus_stop;
    logic          wr_busy;
    logic          wr_kick;
    logic          mem_we;
    logic [7:0]    wr_byte;
    logic [7:0]    rd_byte;
    logic [AW-1:0] cell_addr;

    seeprom_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) sense_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop)
    );

    seeprom_link_ctrl #(.AW(AW), .HI_BITS(HI_BITS)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_lvl(sda_lvl), .bus_start(bus_start), .bus_stop(bus_stop),
        .strap_i(strap_i), .wr_lock_i(wr_lock_i), .busy_i(wr_busy),
        .rd_byte(rd_byte), .sda_pull(sda_pull_o), .mem_we(mem_we),
        .wr_byte(wr_byte), .cell_addr(cell_addr), .wr_kick(wr_kick)
    );

    seeprom_cell_array #(.DEPTH(MEM_BYTES), .AW(AW)) cells_i (
        .clk(clk), .we(mem_we), .addr(cell_addr), .wdata(wr_byte),
        .rdata(rd_byte)
    );

    seeprom_wr_timer #(.CYCLES(WRITE_CYCLES)) timer_i (
        .clk(clk), .rst_n(rst_n), .kick(wr_kick), .busy(wr_busy)
    );
endmodule

// File: rtl/seeprom_slave_chk.sv
// Protocol checker for seeprom_slave, bound into every instance.
module seeprom_slave_chk #(
    parameter int AW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_lvl,
    input logic          sda_pull,
    input logic          busy,
    input logic          mem_we,
    input logic          wr_lock,
    input logic [AW-1:0] addr
);
    // R9
    pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !$past(scl_lvl));

    // R7
    silent_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_pull);

    // R8
    locked_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !wr_lock);

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (addr == $past(addr) + 1'b1));
endmodule

bind seeprom_slave seeprom_slave_chk #(.AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_pull(sda_pull_o),
    .busy(wr_busy), .mem_we(mem_we), .wr_lock(wr_lock_i), .addr(cell_addr)
);

// File: tb/seeprom_slave_tb_top.sv
// Bus-master bench: writes and reads back the whole array and sweeps
// selection codes, with expected bytes computed from a formula.
module seeprom_slave_tb_top;
    localparam int MEM = 512;
    localparam int WRC = 400;
    localparam int H   = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b100;
    logic       lock = 1'b0;
    logic       sda_pull;
    wire        sda_line = sda_m & ~sda_pull;

    int  n_chk = 0;
    int  n_fail = 0;
    int  cyc = 0;
    int  r9_viol = 0;
    bit  done = 1'b0;
    logic prev_pull = 1'b0;

    always #4 clk = ~clk;

    seeprom_slave #(.MEM_BYTES(MEM), .WRITE_CYCLES(WRC)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .strap_i(strap), .wr_lock_i(lock), .sda_pull_o(sda_pull)
    );

    // Cycle count and R9 monitor: pull must not move while SCL is high.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && (sda_pull !== prev_pull) && scl_m) r9_viol <= r9_viol + 1;
        prev_pull <= sda_pull;
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    function automatic logic [7:0] sel(input bit hi, input bit rd);
        return {4'b1010, 2'b10, hi, rd};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(H);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b0; wt(H);
        scl_m = 1'b0; wt(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(H);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b1; wt(H);
    endtask

    task automatic put_bit(input bit b);
        sda_m = b; wt(H);
        scl_m = 1'b1; wt(H);
        scl_m = 1'b0; wt(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; wt(H);
        scl_m = 1'b1; wt(2);
        ack = !sda_line;
        wt(H - 2);
        scl_m = 1'b0; wt(2);
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            wt(H);
            scl_m = 1'b1; wt(2);
            b = {b[6:0], sda_line};
            wt(H - 2);
            scl_m = 1'b0; wt(2);
        end
        sda_m = !ack; wt(H);
        scl_m = 1'b1; wt(H);
        scl_m = 1'b0; wt(2);
        sda_m = 1'b1;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 195000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] b;
        int t0;
        int tries;
        wt(5);
        chk(sda_pull == 1'b0, "R1 pull in reset", sda_pull, 0);
        rst_n = 1'b1; wt(5);
        chk(sda_pull == 1'b0, "R1 pull after reset", sda_pull, 0);
        bus_start(); send_byte(sel(0, 0), ack); bus_stop();
        chk(ack, "R1 first selection acked", ack, 1);

        // R2: sweep the device-code nibble with matching straps.
        for (int n = 0; n < 16; n++) begin
            bus_start(); send_byte({4'(n), 2'b10, 1'b0, 1'b0}, ack); bus_stop();
            chk(ack == (n == 10), "R2 device code", ack, n == 10);
        end
        // R2/R3: sweep bits 3:1; bit 1 is an address bit, never compared.
        for (int s = 0; s < 8; s++) begin
            bus_start(); send_byte({4'b1010, 3'(s), 1'b0}, ack); bus_stop();
            chk(ack == (s[2:1] == 2'b10), "R2 R3 strap compare", ack, s[2:1] == 2'b10);
        end

        // R4: write the whole array in one transfer.
        bus_start(); send_byte(sel(0, 0), ack); send_byte(8'h00, ack);
        chk(ack, "R4 address byte ack", ack, 1);
        for (int a = 0; a < MEM; a++) begin
            send_byte(pat(a), ack);
            chk(ack, "R4 data byte ack", ack, 1);
        end
        bus_stop();
        t0 = cyc;

        // R7: polling sees NACK until the write cycle has run out.
        bus_start(); send_byte(sel(0, 0), ack); bus_stop();
        chk(!ack, "R7 busy selection nacked", ack, 0);
        tries = 0;
        do begin
            bus_start(); send_byte(sel(0, 0), ack);
            if (!ack) bus_stop();
            tries++;
        end while (!ack && tries < 20);
        chk(ack && (cyc - t0) >= WRC, "R7 acked after write cycle", cyc - t0, WRC);
        bus_stop();
        bus_start(); send_byte(sel(0, 0), ack); bus_stop();
        chk(ack, "R7 address-only transfer starts no cycle", ack, 1);

        // R5: read the whole array from cell 0.
        bus_start(); send_byte(sel(0, 0), ack); send_byte(8'h00, ack);
        bus_start(); send_byte(sel(0, 1), ack);
        chk(ack, "R5 read selection ack", ack, 1);
        for (int a = 0; a < MEM; a++) begin
            recv_byte(a != MEM - 1, b);
            chk(b == pat(a), "R5 sequential read", b, pat(a));
        end
        // R6: after the master NACK the slave stays off the line.
        chk(sda_pull == 1'b0, "R6 released after nack", sda_pull, 0);
        wt(H); scl_m = 1'b1; wt(2);
        chk(sda_line == 1'b1, "R6 line high on extra clock", sda_line, 1);
        wt(H - 2); scl_m = 1'b0; wt(2);
        bus_stop();
        // R5: the counter wrapped, so the current-address read returns cell 0.
        bus_start(); send_byte(sel(0, 1), ack); recv_byte(1'b0, b); bus_stop();
        chk(b == pat(0), "R5 wrap to cell 0", b, pat(0));

        // R3/R5: selection bit 1 supplies address bit 8; read across the wrap.
        bus_start(); send_byte(sel(1, 0), ack); send_byte(8'hF8, ack);
        bus_start(); send_byte(sel(1, 1), ack);
        for (int i = 0; i < 16; i++) begin
            recv_byte(i != 15, b);
            chk(b == pat((9'h1F8 + i) % MEM), "R3 R5 high-bit read with wrap", b, pat((9'h1F8 + i) % MEM));
        end
        bus_stop();

        // R8: locked writes are refused and leave the cell alone.
        lock = 1'b1;
        bus_start(); send_byte(sel(0, 0), ack); send_byte(8'h05, ack);
        chk(ack, "R8 address acked while locked", ack, 1);
        send_byte(8'h5A, ack);
        chk(!ack, "R8 data nacked while locked", ack, 0);
        bus_stop();
        lock = 1'b0;
        bus_start(); send_byte(sel(0, 0), ack);
        chk(ack, "R8 no write cycle after locked transfer", ack, 1);
        send_byte(8'h05, ack);
        bus_start(); send_byte(sel(0, 1), ack); recv_byte(1'b0, b); bus_stop();
        chk(b == pat(5), "R8 cell unchanged", b, pat(5));

        // R10: a start in mid-byte drops the partial bits.
        bus_start(); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
        bus_start(); send_byte(sel(0, 0), ack);
        chk(ack, "R10 selection after mid-byte start", ack, 1);
        send_byte(8'h20, ack);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        bus_start(); send_byte(sel(0, 1), ack); recv_byte(1'b0, b); bus_stop();
        chk(b == pat(32), "R10 partial data byte discarded", b, pat(32));
        bus_start(); send_byte(sel(0, 0), ack); bus_stop();
        chk(ack, "R10 no write cycle from partial byte", ack, 1);

        chk(r9_viol == 0, "R9 pull changed with SCL high", r9_viol, 0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule